// File: doc/BRIEF.md
# Set-Associative Write-Back Byte Cache

This block is a byte-addressed cache sitting between a processor-side request port and a block-wide memory port. Its geometry is fixed at elaboration by three exponents: the number of sets (2^SET_BITS), the ways per set (2^WAY_BITS) and the bytes per line (2^OFF_BITS). With WAY_BITS = 0 it is a direct-mapped cache. An address is read from the top as tag, then set index, then byte offset, so it holds 2^(SET_BITS+WAY_BITS+OFF_BITS) data bytes.

The processor side takes one byte read or write per accepted request. Hits answer in the next cycle and never touch memory. A miss picks a victim in the indexed set. If the victim holds modified data, the old line is first written back as one whole-block memory write. The new block is then fetched as one whole-block memory read, and the written byte is merged in on a write miss. Three counters record accepted accesses, hits and misses, so the miss rate can be derived outside the block.

Top module: `cache_sa`

## Requirements
- R1: An address splits, from most to least significant, into tag, set index (SET_BITS wide) and byte offset (OFF_BITS wide). A read returns the byte whose offset within the cached line matches the address offset, and that byte equals the last value written to that address, or the memory content if the address was never written.
- R2: With WAY_BITS = 0, SET_BITS = 2, OFF_BITS = 1 and a 4-bit address, the read sequence 0, 1, 7, 8, 0 from a cold cache gives miss, hit, miss, miss, miss.
- R3: A request that hits is answered exactly one cycle after acceptance, with rsp_hit_o = 1, and causes no memory transaction.
- R4: With WAY_BITS = 1, SET_BITS = 1, OFF_BITS = 1 and a 4-bit address, the read sequence 0, 1, 7, 8, 0 from a cold cache gives miss, hit, miss, miss, hit.
- R5: The victim on a miss is the lowest-numbered invalid way of the set. If every way is valid, it is the least recently used way, where a hit and a fill each make their way the most recent.
- R6: A miss is answered with rsp_hit_o = 0 one cycle after the memory accepts the fill read (mem_req_o = 1, mem_we_o = 0, mem_ack_i = 1). mem_addr_o is the block address (address shifted right by OFF_BITS), and the byte at offset k of a block occupies bits 8k+7 to 8k of the data bus.
- R7: When the victim is valid and modified, its whole block is written to memory at its own block address (mem_we_o = 1) before the fill read starts. Clean or invalid victims cause no memory write.
- R8: A write hit changes only the cached line and marks it modified, with no memory traffic. req_ready_o is high only when no memory transaction is in progress.
- R9: A write miss fetches the block, merges the written byte at its offset and leaves the line marked modified. The memory copy changes only when that line is evicted.
- R10: access_cnt_o, hit_cnt_o and miss_cnt_o count accepted requests, accepted hits and accepted misses, so access equals hit plus miss at all times.
- R11: After reset every line is invalid and unmodified, all counters read zero, req_ready_o is high and no memory request is raised.
- R12: Once mem_req_o is raised, mem_we_o, mem_addr_o and mem_wdata_o stay unchanged until mem_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_we_i | input | 1 | 1 = byte write, 0 = byte read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 8 | Byte to write |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_rdata_o | output | 8 | Byte read, or the byte written on a write |
| rsp_hit_o | output | 1 | Response came from a hit |
| mem_req_o | output | 1 | Memory transaction active |
| mem_we_o | output | 1 | 1 = block write-back, 0 = block fill |
| mem_addr_o | output | ADDR_W-OFF_BITS | Block address |
| mem_wdata_o | output | 8<<OFF_BITS | Block written back |
| mem_ack_i | input | 1 | Memory completes the transaction this cycle |
| mem_rdata_i | input | 8<<OFF_BITS | Fill block, valid with mem_ack_i |
| access_cnt_o | output | CNT_W | Accepted requests |
| hit_cnt_o | output | CNT_W | Accepted hits |
| miss_cnt_o | output | CNT_W | Accepted misses |

## Verification
The checker assumes that the memory acknowledges only while a request is raised and gives a fill block in the same cycle as its acknowledge. The bench memory model meets this: it acknowledges exactly one cycle after a request appears, or reappears after a gap, and drives read data combinationally from its own block array. On the processor side, a request is held until it is accepted and then dropped before the response arrives, so no second request overlaps a miss. Two instances are driven: a two-way one and a direct-mapped one. The address sequences are chosen so that clean, invalid and modified victims each occur on known sets.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } cache_state_e;
endpackage

// File: rtl/cache_lookup.sv
module cache_lookup #(
  parameter int WAYS   = 2,
  parameter int WAY_IW = 1,
  parameter int TAG_W  = 4
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_IW-1:0]          hit_way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way_o = WAY_IW'(w);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int SETS     = 4,
  parameter int SET_BITS = 2,
  parameter int WAYS     = 2,
  parameter int WAY_IW   = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SET_BITS-1:0] set_i,
  input  logic [WAYS-1:0]     valid_i,
  output logic [WAY_IW-1:0]   victim_o,
  input  logic                touch_i,
  input  logic [WAY_IW-1:0]   touch_way_i
);
  localparam logic [WAY_IW-1:0] OLDEST = WAY_IW'(WAYS - 1);

  // age 0 = most recent; ages of a set are always a permutation
  logic [WAYS-1:0][WAY_IW-1:0] age_q [SETS];
  logic found_inv;

  always_comb begin
    found_inv = 1'b0;
    victim_o  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !found_inv) begin
        victim_o  = WAY_IW'(w);
        found_inv = 1'b1;
      end
    end
    if (!found_inv) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[set_i][w] == OLDEST) victim_o = WAY_IW'(w);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_IW'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_IW'(w) == touch_way_i)
          age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < age_q[set_i][touch_way_i])
          age_q[set_i][w] <= age_q[set_i][w] + WAY_IW'(1);
      end
    end
  end
endmodule

// File: rtl/cache_stats.sv
module cache_stats #(
  parameter int CNT_W = 16,
  parameter int N     = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0]              inc_i,
  output logic [N-1:0][CNT_W-1:0]   cnt_o
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_o[i] <= '0;
      else if (inc_i[i]) cnt_o[i] <= cnt_o[i] + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cache_sa.sv
module cache_sa
  import cache_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SET_BITS = 2,
  parameter int WAY_BITS = 1,
  parameter int OFF_BITS = 2,
  parameter int CNT_W    = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic                        req_we_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [7:0]                  req_wdata_i,
  output logic                        rsp_valid_o,
  output logic [7:0]                  rsp_rdata_o,
  output logic                        rsp_hit_o,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [ADDR_W-OFF_BITS-1:0]  mem_addr_o,
  output logic [(8<<OFF_BITS)-1:0]    mem_wdata_o,
  input  logic                        mem_ack_i,
  input  logic [(8<<OFF_BITS)-1:0]    mem_rdata_i,
  output logic [CNT_W-1:0]            access_cnt_o,
  output logic [CNT_W-1:0]            hit_cnt_o,
  output logic [CNT_W-1:0]            miss_cnt_o
);
  localparam int SETS   = 1 << SET_BITS;
  localparam int WAYS   = 1 << WAY_BITS;
  localparam int BLK_W  = 8 << OFF_BITS;
  localparam int TAG_W  = ADDR_W - SET_BITS - OFF_BITS;
  localparam int WAY_IW = (WAY_BITS > 0) ? WAY_BITS : 1;

  cache_state_e state_q, state_d;

  logic [SETS-1:0][WAYS-1:0]   valid_q, dirty_q;
  logic [WAYS-1:0][TAG_W-1:0]  tag_q  [SETS];
  logic [WAYS-1:0][BLK_W-1:0]  data_q [SETS];

  logic [ADDR_W-1:0] q_addr;
  logic              q_we;
  logic [7:0]        q_wdata;
  logic [WAY_IW-1:0] q_way;

  logic               in_idle, accept, lk_hit, vic_dirty, fill_done;
  logic [ADDR_W-1:0]  cur_addr;
  logic [TAG_W-1:0]   cur_tag;
  logic [SET_BITS-1:0] cur_set;
  logic [OFF_BITS-1:0] cur_off;
  logic [WAY_IW-1:0]  lk_way, vic_way;
  logic [BLK_W-1:0]   hit_blk, hit_wblk, fill_blk;

  function automatic logic [BLK_W-1:0] put_byte(logic [BLK_W-1:0] blk,
                                                logic [OFF_BITS-1:0] off,
                                                logic [7:0] b);
    logic [BLK_W-1:0] r;
    r = blk;
    r[{off, 3'b000} +: 8] = b;
    return r;
  endfunction

  assign in_idle  = (state_q == ST_IDLE);
  assign accept   = req_valid_i && in_idle;
  assign cur_addr = in_idle ? req_addr_i : q_addr;
  assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
  assign cur_set  = cur_addr[OFF_BITS +: SET_BITS];
  assign cur_off  = cur_addr[OFF_BITS-1:0];

  cache_lookup #(.WAYS(WAYS), .WAY_IW(WAY_IW), .TAG_W(TAG_W)) u_lookup (
    .valid_i   (valid_q[cur_set]),
    .tags_i    (tag_q[cur_set]),
    .tag_i     (cur_tag),
    .hit_o     (lk_hit),
    .hit_way_o (lk_way)
  );

  cache_lru #(.SETS(SETS), .SET_BITS(SET_BITS), .WAYS(WAYS), .WAY_IW(WAY_IW)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (cur_set),
    .valid_i     (valid_q[cur_set]),
    .victim_o    (vic_way),
    .touch_i     ((accept && lk_hit) || fill_done),
    .touch_way_i (fill_done ? q_way : lk_way)
  );

  logic [2:0][CNT_W-1:0] cnt;
  cache_stats #(.CNT_W(CNT_W), .N(3)) u_stats (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  ({accept && !lk_hit, accept && lk_hit, accept}),
    .cnt_o  (cnt)
  );
  assign access_cnt_o = cnt[0];
  assign hit_cnt_o    = cnt[1];
  assign miss_cnt_o   = cnt[2];

  assign vic_dirty = valid_q[cur_set][vic_way] && dirty_q[cur_set][vic_way];
  assign fill_done = (state_q == ST_FILL) && mem_ack_i;
  assign hit_blk   = data_q[cur_set][lk_way];
  assign hit_wblk  = put_byte(hit_blk, cur_off, req_wdata_i);
  assign fill_blk  = q_we ? put_byte(mem_rdata_i, cur_off, q_wdata) : mem_rdata_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept && !lk_hit) state_d = vic_dirty ? ST_WBACK : ST_FILL;
      ST_WBACK: if (mem_ack_i) state_d = ST_FILL;
      ST_FILL:  if (mem_ack_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign req_ready_o = in_idle;
  assign mem_req_o   = !in_idle;
  assign mem_we_o    = (state_q == ST_WBACK);
  assign mem_addr_o  = mem_we_o ? {tag_q[cur_set][q_way], cur_set} : cur_addr[ADDR_W-1:OFF_BITS];
  assign mem_wdata_o = data_q[cur_set][q_way];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      q_addr  <= '0;
      q_we    <= 1'b0;
      q_wdata <= '0;
      q_way   <= '0;
    end else begin
      state_q <= state_d;
      if (accept && !lk_hit) begin
        q_addr  <= req_addr_i;
        q_we    <= req_we_i;
        q_wdata <= req_wdata_i;
        q_way   <= vic_way;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (accept && lk_hit && req_we_i) dirty_q[cur_set][lk_way] <= 1'b1;
      if (fill_done) begin
        valid_q[cur_set][q_way] <= 1'b1;
        dirty_q[cur_set][q_way] <= q_we;
      end
    end
  end

  // line contents need no reset: valid bits gate them
  always_ff @(posedge clk_i) begin
    if (accept && lk_hit && req_we_i) data_q[cur_set][lk_way] <= hit_wblk;
    if (fill_done) begin
      data_q[cur_set][q_way] <= fill_blk;
      tag_q[cur_set][q_way]  <= cur_tag;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= (accept && lk_hit) || fill_done;
      rsp_hit_o   <= accept && lk_hit;
      if (accept && lk_hit)
        rsp_rdata_o <= req_we_i ? req_wdata_i : hit_blk[{cur_off, 3'b000} +: 8];
      else if (fill_done)
        rsp_rdata_o <= fill_blk[{cur_off, 3'b000} +: 8];
    end
  end
endmodule

// File: rtl/cache_sa_chk.sv
module cache_sa_chk #(
  parameter int BADDR_W = 6,
  parameter int BLK_W   = 32,
  parameter int CNT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               rsp_valid_o,
  input logic               rsp_hit_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [BADDR_W-1:0] mem_addr_o,
  input logic [BLK_W-1:0]   mem_wdata_o,
  input logic               mem_ack_i,
  input logic [CNT_W-1:0]   access_cnt_o,
  input logic [CNT_W-1:0]   hit_cnt_o,
  input logic [CNT_W-1:0]   miss_cnt_o
);
  assert_busy_not_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  assert_mem_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)
                                 && $stable(mem_wdata_o));

  assert_wb_then_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i |=> mem_req_o && !mem_we_o);

  assert_hit_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> $past(req_valid_i && req_ready_o));

  assert_miss_after_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> $past(mem_req_o && mem_ack_i && !mem_we_o));

  assert_count_sum_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_cnt_o == CNT_W'(hit_cnt_o + miss_cnt_o));
endmodule

bind cache_sa cache_sa_chk #(
  .BADDR_W (ADDR_W - OFF_BITS),
  .BLK_W   (8 << OFF_BITS),
  .CNT_W   (CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_hit_o    (rsp_hit_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ack_i    (mem_ack_i),
  .access_cnt_o (access_cnt_o),
  .hit_cnt_o    (hit_cnt_o),
  .miss_cnt_o   (miss_cnt_o)
);

// File: tb/tb_cache_sa.sv
`timescale 1ns/1ps
module tb_cache_sa;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int nchecks = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic       a_valid = 1'b0, b_valid = 1'b0;
  logic       req_we = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;

  logic       a_ready, a_rsp_v, a_hit, a_mreq, a_mwe, a_ack;
  logic [7:0] a_rdata;
  logic [2:0] a_maddr;
  logic [15:0] a_mwdata, a_mrdata;
  logic [7:0] a_acc, a_hits, a_miss;

  logic       b_ready, b_rsp_v, b_hit, b_mreq, b_mwe, b_ack;
  logic [7:0] b_rdata;
  logic [2:0] b_maddr;
  logic [15:0] b_mwdata, b_mrdata;
  logic [7:0] b_acc, b_hits, b_miss;

  // two-way: 2 sets, 2 ways, 2-byte lines
  cache_sa #(.ADDR_W(4), .SET_BITS(1), .WAY_BITS(1), .OFF_BITS(1), .CNT_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(a_valid), .req_ready_o(a_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(a_rsp_v), .rsp_rdata_o(a_rdata), .rsp_hit_o(a_hit),
    .mem_req_o(a_mreq), .mem_we_o(a_mwe), .mem_addr_o(a_maddr),
    .mem_wdata_o(a_mwdata), .mem_ack_i(a_ack), .mem_rdata_i(a_mrdata),
    .access_cnt_o(a_acc), .hit_cnt_o(a_hits), .miss_cnt_o(a_miss)
  );

  // direct-mapped: 4 sets, 1 way, 2-byte lines
  cache_sa #(.ADDR_W(4), .SET_BITS(2), .WAY_BITS(0), .OFF_BITS(1), .CNT_W(8)) dut_dm (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(b_valid), .req_ready_o(b_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(b_rsp_v), .rsp_rdata_o(b_rdata), .rsp_hit_o(b_hit),
    .mem_req_o(b_mreq), .mem_we_o(b_mwe), .mem_addr_o(b_maddr),
    .mem_wdata_o(b_mwdata), .mem_ack_i(b_ack), .mem_rdata_i(b_mrdata),
    .access_cnt_o(b_acc), .hit_cnt_o(b_hits), .miss_cnt_o(b_miss)
  );

  function automatic logic [7:0] init_byte(int a);
    return 8'((a * 17 + 5) & 255);
  endfunction

  // memory models: ack one cycle after request
  logic [15:0] mem_a [8];
  logic [15:0] mem_b [8];
  int wb_a = 0, wb_b = 0, fill_a = 0, fill_b = 0;
  assign a_mrdata = mem_a[a_maddr];
  assign b_mrdata = mem_b[b_maddr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_ack <= 1'b0;
      for (int k = 0; k < 8; k++) mem_a[k] <= {init_byte(2*k+1), init_byte(2*k)};
    end else begin
      a_ack <= a_mreq && !a_ack;
      if (a_mreq && a_ack) begin
        if (a_mwe) begin mem_a[a_maddr] <= a_mwdata; wb_a <= wb_a + 1; end
        else fill_a <= fill_a + 1;
      end
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_ack <= 1'b0;
      for (int k = 0; k < 8; k++) mem_b[k] <= {init_byte(2*k+1), init_byte(2*k)};
    end else begin
      b_ack <= b_mreq && !b_ack;
      if (b_mreq && b_ack) begin
        if (b_mwe) begin mem_b[b_maddr] <= b_mwdata; wb_b <= wb_b + 1; end
        else fill_b <= fill_b + 1;
      end
    end
  end

  int busy_viol = 0;
  always @(negedge clk) begin
    if ((a_mreq && a_ready) || (b_mreq && b_ready)) busy_viol++;
  end

  logic tsel = 1'b0;
  logic c_ready, c_rsp_v, c_hit;
  logic [7:0] c_rdata;
  assign c_ready = tsel ? b_ready : a_ready;
  assign c_rsp_v = tsel ? b_rsp_v : a_rsp_v;
  assign c_hit   = tsel ? b_hit   : a_hit;
  assign c_rdata = tsel ? b_rdata : a_rdata;

  logic [7:0] ref_a [16];
  logic [7:0] ref_b [16];
  int exp_hit_a = 0, exp_miss_a = 0, exp_hit_b = 0, exp_miss_b = 0;

  task automatic check_eq(string tag, int act, int exp);
    nchecks++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_acc(input bit we, input logic [3:0] addr, input logic [7:0] wd,
                        output logic [7:0] rd, output bit hit, output int lat);
    @(negedge clk);
    req_we = we; req_addr = addr; req_wdata = wd;
    if (tsel) b_valid = 1'b1; else a_valid = 1'b1;
    while (!c_ready) @(negedge clk);
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b0;
    lat = 1;
    while (!c_rsp_v) begin @(negedge clk); lat++; end
    rd = c_rdata;
    hit = c_hit;
  endtask

  task automatic acc_chk(input bit sel, input bit we, input logic [3:0] addr,
                         input logic [7:0] wd, input bit exp_hit, input string tag);
    logic [7:0] rd, exp_rd;
    bit hit;
    int lat;
    tsel = sel;
    do_acc(we, addr, wd, rd, hit, lat);
    check_eq({tag, " hit flag"}, int'(hit), int'(exp_hit));
    if (we) begin
      exp_rd = wd;
      if (sel) ref_b[addr] = wd; else ref_a[addr] = wd;
    end else exp_rd = sel ? ref_b[addr] : ref_a[addr];
    check_eq({tag, " R1 data"}, int'(rd), int'(exp_rd));
    if (exp_hit) check_eq({tag, " R3 hit latency"}, lat, 1);
    else check_eq({tag, " R6 miss latency>=3"}, int'(lat >= 3), 1);
    if (sel) begin if (exp_hit) exp_hit_b++; else exp_miss_b++; end
    else     begin if (exp_hit) exp_hit_a++; else exp_miss_a++; end
  endtask

  task automatic check_counts(input bit sel, input string tag);
    @(negedge clk);
    if (sel) begin
      check_eq({tag, " R10 access"}, int'(b_acc), exp_hit_b + exp_miss_b);
      check_eq({tag, " R10 hits"}, int'(b_hits), exp_hit_b);
      check_eq({tag, " R10 misses"}, int'(b_miss), exp_miss_b);
    end else begin
      check_eq({tag, " R10 access"}, int'(a_acc), exp_hit_a + exp_miss_a);
      check_eq({tag, " R10 hits"}, int'(a_hits), exp_hit_a);
      check_eq({tag, " R10 misses"}, int'(a_miss), exp_miss_a);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_eq("R11 ready after reset", int'(a_ready && b_ready), 1);
    check_eq("R11 no mem request", int'(a_mreq || b_mreq), 0);
    check_eq("R11 counters zero", int'(a_acc) + int'(a_hits) + int'(a_miss)
             + int'(b_acc) + int'(b_hits) + int'(b_miss), 0);
    check_eq("R11 no response", int'(a_rsp_v || b_rsp_v), 0);
  endtask

  task automatic t_dm_trace;
    acc_chk(1'b1, 1'b0, 4'd0, 8'd0, 1'b0, "R2 rd0");
    acc_chk(1'b1, 1'b0, 4'd1, 8'd0, 1'b1, "R2 rd1");
    acc_chk(1'b1, 1'b0, 4'd7, 8'd0, 1'b0, "R2 rd7");
    acc_chk(1'b1, 1'b0, 4'd8, 8'd0, 1'b0, "R2 rd8");
    acc_chk(1'b1, 1'b0, 4'd0, 8'd0, 1'b0, "R2 rd0 again");
    check_eq("R7 dm trace no write-back", wb_b, 0);
    check_counts(1'b1, "R2 dm");
  endtask

  task automatic t_sa_trace;
    acc_chk(1'b0, 1'b0, 4'd0, 8'd0, 1'b0, "R4 rd0");
    acc_chk(1'b0, 1'b0, 4'd1, 8'd0, 1'b1, "R4 rd1");
    acc_chk(1'b0, 1'b0, 4'd7, 8'd0, 1'b0, "R4 rd7");
    acc_chk(1'b0, 1'b0, 4'd8, 8'd0, 1'b0, "R4 rd8");
    acc_chk(1'b0, 1'b0, 4'd0, 8'd0, 1'b1, "R4 rd0 again");
    check_counts(1'b0, "R4 2way");
  endtask

  task automatic t_lru_wb;
    int f0;
    f0 = fill_a;
    acc_chk(1'b0, 1'b1, 4'd0, 8'h3C, 1'b1, "R8 write hit");
    check_eq("R8 write hit no memory traffic", (wb_a) + (fill_a - f0), 0);
    check_eq("R8 memory unchanged", int'(mem_a[0][7:0]), int'(init_byte(0)));
    acc_chk(1'b0, 1'b0, 4'd4, 8'd0, 1'b0, "R5 rd4 evicts 8");
    check_eq("R7 clean victim not written", wb_a, 0);
    acc_chk(1'b0, 1'b0, 4'd0, 8'd0, 1'b1, "R5 rd0 kept");
    acc_chk(1'b0, 1'b0, 4'd8, 8'd0, 1'b0, "R5 rd8 evicts 4");
    acc_chk(1'b0, 1'b0, 4'd12, 8'd0, 1'b0, "R7 rd12 evicts dirty 0");
    check_eq("R7 one write-back", wb_a, 1);
    check_eq("R7 written-back byte", int'(mem_a[0][7:0]), 8'h3C);
    acc_chk(1'b0, 1'b0, 4'd0, 8'd0, 1'b0, "R6 rd0 refetched");
    check_eq("R7 no extra write-back", wb_a, 1);
    acc_chk(1'b0, 1'b0, 4'd1, 8'd0, 1'b1, "R1 rd1 offset");
    acc_chk(1'b0, 1'b0, 4'd6, 8'd0, 1'b1, "R1 rd6 other set");
    check_counts(1'b0, "R5 2way");
  endtask

  task automatic t_write_alloc;
    acc_chk(1'b1, 1'b1, 4'd13, 8'h5A, 1'b0, "R9 write miss");
    check_eq("R9 invalid victim no write-back", wb_b, 0);
    check_eq("R9 memory not yet updated", int'(mem_b[6][15:8]), int'(init_byte(13)));
    acc_chk(1'b1, 1'b0, 4'd12, 8'd0, 1'b1, "R9 rd12 neighbour");
    acc_chk(1'b1, 1'b0, 4'd13, 8'd0, 1'b1, "R9 rd13 merged");
    acc_chk(1'b1, 1'b0, 4'd5, 8'd0, 1'b0, "R7 rd5 evicts dirty");
    check_eq("R7 dm write-back", wb_b, 1);
    check_eq("R9 written byte in memory", int'(mem_b[6][15:8]), 8'h5A);
    check_eq("R9 untouched byte in memory", int'(mem_b[6][7:0]), int'(init_byte(12)));
    acc_chk(1'b1, 1'b0, 4'd13, 8'd0, 1'b0, "R9 rd13 refetch");
    check_eq("R7 clean victim dm", wb_b, 1);
    acc_chk(1'b1, 1'b1, 4'd9, 8'h77, 1'b0, "R9 write miss clean victim");
    acc_chk(1'b1, 1'b1, 4'd8, 8'h11, 1'b1, "R8 write hit dm");
    acc_chk(1'b1, 1'b0, 4'd9, 8'd0, 1'b1, "R1 rd9");
    acc_chk(1'b1, 1'b0, 4'd0, 8'd0, 1'b0, "R7 rd0 evicts dirty 8-9");
    check_eq("R7 second write-back", wb_b, 2);
    check_eq("R7 block 4 written", int'(mem_b[4]), 16'h7711);
    check_counts(1'b1, "R9 dm");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      ref_a[i] = init_byte(i);
      ref_b[i] = init_byte(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dm_trace();
    t_sa_trace();
    t_lru_wb();
    t_write_alloc();
    check_eq("R8 ready low while memory busy", busy_viol, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nerr++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end
endmodule